// File: doc/BRIEF.md
# Shared FM0 / Manchester Line Encoder

This block turns a serial stream of data bits into a two-level line waveform. Each bit occupies one symbol made of two equal halves. The boundaries of the halves are marked by a single-cycle half-symbol strobe from the surrounding logic. A mode select chooses between FM0 (bi-phase space) coding and Manchester coding. Both codes run through one datapath: a two-bit symbol state register, one XOR that forms the second-half level, and one 2:1 mux that drives the line from either state bit.

A symbol boundary is any strobe that arrives while the encoder is not in a first half. At a boundary the encoder samples the data bit, the valid flag and the mode. If the valid flag is set, it loads the two half levels of the new symbol and raises the first-half flag. The next strobe moves the encoder into the second half, and the strobe after that is the next boundary. If the valid flag is low at a boundary, the line stays where it is until a later boundary.

Top module: `lineEncoderTop`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `lineOut` is 1 and `firstHalf` is 0. The internal symbol state is A=1, B=1.
- R2: In FM0 mode (`modeSel`=0), the first-half level of every symbol is the inverse of the line level that was driven just before the boundary.
- R3: In FM0 mode, a data bit of 0 makes the second half the inverse of the first half. A data bit of 1 makes the second half equal to the first half.
- R4: In Manchester mode (`modeSel`=1), a data bit of 1 drives 1 then 0, and a data bit of 0 drives 0 then 1.
- R5: `firstHalf` rises on the clock edge that samples a boundary strobe with `dataValid`=1. It falls on the edge that samples the next strobe.
- R6: A boundary strobe with `dataValid`=0 leaves `lineOut` unchanged and `firstHalf` at 0.
- R7: `dataIn`, `modeSel` and `dataValid` are sampled only at a boundary strobe. Their values at the mid-symbol strobe have no effect on the second-half level.
- R8: `lineOut` and `firstHalf` change only on a clock edge that samples `halfTick`=1.
- R9: After a Manchester symbol, the first half of a following FM0 symbol is the inverse of the Manchester symbol's second-half level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| halfTick | input | 1 | One-cycle strobe marking the start of each half symbol |
| dataIn | input | 1 | Data bit to encode, sampled at a symbol boundary |
| dataValid | input | 1 | Qualifies `dataIn` at a symbol boundary |
| modeSel | input | 1 | 0 selects FM0 coding, 1 selects Manchester coding |
| lineOut | output | 1 | Encoded line level |
| firstHalf | output | 1 | High during the first half of a symbol being sent |

## Verification
The bench runs several kinds of stimulus. An FM0 run with alternating zeros and ones separates the mid-symbol inversion from the hold case. Runs of equal bits expose a missing boundary inversion. Manchester symbols of both values fix the polarity. Mixed sequences that switch mode between symbols show whether the two codes really share their state, since an FM0 symbol must invert the last Manchester level. The bench also scrambles data, mode and valid at the mid-symbol strobe and inserts idle boundaries, which shows whether the inputs are sampled only at boundaries and whether the line holds its level while idle. A behavioural waveform model is compared with both outputs on every clock.

// File: rtl/lineEncPkg.sv
package lineEncPkg;

  typedef enum logic {
    CODE_FM0 = 1'b0,
    CODE_MAN = 1'b1
  } codeSel_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic     loadSym;   // boundary with valid data: load a new symbol
    codeSel_e code;      // code chosen for the symbol being loaded
    logic     bitVal;    // data bit of the symbol being loaded
    logic     inFirst;   // drive the first-half level
  } encStrobes_t;

endpackage

// File: rtl/lineEncCtrl.sv
module lineEncCtrl
  import lineEncPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        halfTick,
  input  logic        dataIn,
  input  logic        dataValid,
  input  logic        modeSel,
  output encStrobes_t strobes
);

  logic firstQ;
  logic atBoundary;
  logic startSym;
  logic endFirst;

  // a strobe outside a first half is a symbol boundary
  assign atBoundary = halfTick & ~firstQ;
  assign startSym   = atBoundary & dataValid;
  assign endFirst   = halfTick & firstQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      firstQ <= 1'b0;
    end else if (startSym) begin
      firstQ <= 1'b1;
    end else if (endFirst) begin
      firstQ <= 1'b0;
    end
  end

  always_comb begin
    strobes.loadSym = startSym;
    strobes.code    = modeSel ? CODE_MAN : CODE_FM0;
    strobes.bitVal  = dataIn;
    strobes.inFirst = firstQ;
  end

endmodule

// File: rtl/lineEncPath.sv
module lineEncPath
  import lineEncPkg::*;
#(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  encStrobes_t strobes,
  output logic        lineLvl
);

  logic stA;
  logic stB;
  logic nextA;
  logic nextB;
  logic fm0Sel;

  assign fm0Sel = (strobes.code == CODE_FM0);

  // FM0: the first half inverts the previous second half.
  // Manchester: the first half is the bit itself.
  assign nextA = fm0Sel ? ~stB : strobes.bitVal;

  // One shared XOR. In FM0 a 1 keeps the level and a 0 flips it.
  // In Manchester the second half always flips.
  assign nextB = nextA ^ ~(strobes.bitVal & fm0Sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      stA <= RESET_LEVEL;
      stB <= RESET_LEVEL;
    end else if (strobes.loadSym) begin
      stA <= nextA;
      stB <= nextB;
    end
  end

  // single 2:1 mux drives the line
  assign lineLvl = strobes.inFirst ? stA : stB;

endmodule

// File: rtl/lineEncoderTop.sv
module lineEncoderTop
  import lineEncPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic halfTick,
  input  logic dataIn,
  input  logic dataValid,
  input  logic modeSel,
  output logic lineOut,
  output logic firstHalf
);

  encStrobes_t strobes;

  lineEncCtrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .halfTick  (halfTick),
    .dataIn    (dataIn),
    .dataValid (dataValid),
    .modeSel   (modeSel),
    .strobes   (strobes)
  );

  lineEncPath #(
    .RESET_LEVEL (1'b1)
  ) uPath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .lineLvl (lineOut)
  );

  assign firstHalf = strobes.inFirst;

endmodule

// File: rtl/lineEncoderChk.sv
module lineEncoderChk (
  input logic clk,
  input logic rst,
  input logic halfTick,
  input logic dataIn,
  input logic dataValid,
  input logic modeSel,
  input logic lineOut,
  input logic firstHalf
);

  logic pastRst;
  logic capMode;
  logic capBit;

  always_ff @(posedge clk) begin
    pastRst <= rst;
    if (halfTick && !firstHalf && dataValid) begin
      capMode <= modeSel;
      capBit  <= dataIn;
    end
  end

  // R1: outputs idle high with no first half right after reset
  always_ff @(posedge clk) begin
    if (pastRst) begin
      a_r1_reset_idle: assert (lineOut == 1'b1 && firstHalf == 1'b0);
    end
  end

  // R2: an FM0 symbol starts with an inversion
  a_r2_fm0_edge: assert property (@(posedge clk) disable iff (rst)
    ($rose(firstHalf) && !$past(modeSel)) |-> (lineOut != $past(lineOut)));

  // R3: FM0 second half depends on the data bit
  a_r3_fm0_mid: assert property (@(posedge clk) disable iff (rst)
    ($fell(firstHalf) && !capMode) |->
      (lineOut == (capBit ? $past(lineOut) : !$past(lineOut))));

  // R4: Manchester first half equals the data bit
  a_r4_man_first: assert property (@(posedge clk) disable iff (rst)
    ($rose(firstHalf) && $past(modeSel)) |-> (lineOut == $past(dataIn)));

  // R4: Manchester second half is the inverse of the first
  a_r4_man_second: assert property (@(posedge clk) disable iff (rst)
    ($fell(firstHalf) && capMode) |-> (lineOut != $past(lineOut)));

  // R5: a first half lasts until the next strobe
  a_r5_first_ends: assert property (@(posedge clk) disable iff (rst)
    (firstHalf && halfTick) |=> !firstHalf);

  // R6: an idle boundary holds the line
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (halfTick && !firstHalf && !dataValid) |=> ($stable(lineOut) && !firstHalf));

  // R8: nothing moves without a strobe
  a_r8_no_tick_stable: assert property (@(posedge clk) disable iff (rst)
    !halfTick |=> ($stable(lineOut) && $stable(firstHalf)));

endmodule

bind lineEncoderTop lineEncoderChk uChk (
  .clk       (clk),
  .rst       (rst),
  .halfTick  (halfTick),
  .dataIn    (dataIn),
  .dataValid (dataValid),
  .modeSel   (modeSel),
  .lineOut   (lineOut),
  .firstHalf (firstHalf)
);

// File: tb/tb_lineEncoderTop.sv
module tb_lineEncoderTop;

  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 2;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst;
  logic halfTick;
  logic dataIn;
  logic dataValid;
  logic modeSel;
  logic lineOut;
  logic firstHalf;

  int testsRun = 0;
  int testsFail = 0;
  bit done = 1'b0;
  bit cmpOn = 1'b0;

  // behavioural waveform model
  bit refFirstLvl = 1'b1;
  bit refSecondLvl = 1'b1;
  bit refInFirst = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lineEncoderTop dut (
    .clk       (clk),
    .rst       (rst),
    .halfTick  (halfTick),
    .dataIn    (dataIn),
    .dataValid (dataValid),
    .modeSel   (modeSel),
    .lineOut   (lineOut),
    .firstHalf (firstHalf)
  );

  always @(posedge clk) begin
    if (rst) begin
      refInFirst   <= 1'b0;
      refFirstLvl  <= 1'b1;
      refSecondLvl <= 1'b1;
    end else if (halfTick) begin
      if (refInFirst) begin
        refInFirst <= 1'b0;
      end else if (dataValid) begin
        refInFirst <= 1'b1;
        if (modeSel) begin
          refFirstLvl  <= dataIn;
          refSecondLvl <= !dataIn;
        end else begin
          refFirstLvl  <= !refSecondLvl;
          refSecondLvl <= dataIn ? !refSecondLvl : refSecondLvl;
        end
      end
    end
  end

  task automatic check(input string tag, input bit act, input bit exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock (R8 line, R5 flag)
  always @(negedge clk) begin
    if (cmpOn && !done) begin
      check("R8", lineOut, refInFirst ? refFirstLvl : refSecondLvl);
      check("R5", firstHalf, refInFirst);
    end
  end

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // sends one symbol; scrambles all inputs at the mid strobe (R7)
  task automatic sendSym(input bit mode, input bit b, output bit fLvl, output bit sLvl);
    dataValid = 1'b1; dataIn = b; modeSel = mode; halfTick = 1'b1;
    @(negedge clk);
    halfTick = 1'b0;
    fLvl = lineOut;
    check("R5", firstHalf, 1'b1);
    idleCycles(GAP);
    dataValid = 1'b0; dataIn = !b; modeSel = !mode; halfTick = 1'b1;
    @(negedge clk);
    halfTick = 1'b0;
    sLvl = lineOut;
    check("R5", firstHalf, 1'b0);
    idleCycles(GAP);
  endtask

  task automatic idleBoundary();
    dataValid = 1'b0; halfTick = 1'b1;
    @(negedge clk);
    halfTick = 1'b0;
    idleCycles(GAP);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      testsFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    bit f;
    bit s;
    bit last;
    bit seqBits[8] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    rst = 1'b1; halfTick = 1'b0; dataIn = 1'b0; dataValid = 1'b0; modeSel = 1'b0;
    idleCycles(3);
    check("R1", lineOut, 1'b1);
    check("R1", firstHalf, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", lineOut, 1'b1);
    check("R1", firstHalf, 1'b0);
    cmpOn = 1'b1;

    // FM0 0 from level 1: 0 then 1
    sendSym(1'b0, 1'b0, f, s);
    check("R2", f, 1'b0);
    check("R3", s, 1'b1);
    check("R7", s, 1'b1);
    // FM0 1: 0 then 0
    sendSym(1'b0, 1'b1, f, s);
    check("R2", f, 1'b0);
    check("R3", s, 1'b0);
    // idle boundary holds 0
    idleBoundary();
    check("R6", lineOut, 1'b0);
    check("R6", firstHalf, 1'b0);
    // Manchester 1: 1 then 0
    sendSym(1'b1, 1'b1, f, s);
    check("R4", f, 1'b1);
    check("R4", s, 1'b0);
    // FM0 1 after Manchester: 1 then 1
    sendSym(1'b0, 1'b1, f, s);
    check("R9", f, 1'b1);
    check("R3", s, 1'b1);
    // Manchester 0: 0 then 1
    sendSym(1'b1, 1'b0, f, s);
    check("R4", f, 1'b0);
    check("R4", s, 1'b1);
    check("R7", s, 1'b1);
    // FM0 0 after Manchester ending high: 0 then 1
    sendSym(1'b0, 1'b0, f, s);
    check("R9", f, 1'b0);
    check("R3", s, 1'b1);

    // FM0 sequence with runs and alternations
    last = s;
    foreach (seqBits[i]) begin
      sendSym(1'b0, seqBits[i], f, s);
      check("R2", f, !last);
      check("R3", s, seqBits[i] ? f : !f);
      last = s;
    end
    // Manchester sequence
    foreach (seqBits[i]) begin
      sendSym(1'b1, seqBits[i], f, s);
      check("R4", f, seqBits[i]);
      check("R4", s, !seqBits[i]);
    end
    // several idle boundaries, then resume in FM0
    last = lineOut;
    for (int k = 0; k < 3; k++) begin
      idleBoundary();
      check("R6", lineOut, last);
    end
    sendSym(1'b0, 1'b1, f, s);
    check("R9", f, !last);
    // back-to-back strobes with no gap
    dataValid = 1'b1; dataIn = 1'b0; modeSel = 1'b1; halfTick = 1'b1;
    @(negedge clk);
    check("R4", lineOut, 1'b0);
    @(negedge clk);
    check("R4", lineOut, 1'b1);
    halfTick = 1'b0;
    idleCycles(GAP);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule